// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. It watches a free-running 64-bit main counter, which is supplied from outside, and raises an edge interrupt when the counter reaches a programmed compare value. Software sets the channel up through a small 32-bit register window. The window holds a configuration word, a comparator that is reached as two 32-bit halves, and a routing word.

The channel runs in one-shot or periodic mode. It compares either the full 64 bits or only the low 32 bits. The narrow width applies when the channel is built without 64-bit capability, or when software sets a force-narrow bit. After a periodic match, the comparator moves forward by the period until it is ahead of the counter again. All comparisons use a wrap-safe signed difference. A narrow one-shot channel also interrupts when the low 32 bits of the counter roll over.

Each event produces a one-cycle request pulse, gated by an enable bit. Each event also sets a sticky status bit, which software clears by writing a one.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset, both comparator halves read 0xFFFFFFFF, irq_o and status_o are 0, and the configuration word at offset 0x00 reads 0x30. In that value, bit 4 is a constant 1 (periodic capable) and bit 5 equals WIDE_CAP (64-bit capable).
- R2: Configuration bits under mask 0xFFFF80B1 keep their value when the word at 0x00 is written. Bit 1, bit 2 (irq enable), bit 3 (periodic), bit 6 and bits 8..14 (bit 8 = force narrow) take the written data. The word at 0x04 is read-only and returns ROUTE_CAP.
- R3: The comparator low half sits at offset 0x08 and the high half at 0x0C. A write to one half leaves the other half unchanged.
- R4: The channel compares 32 bits when WIDE_CAP is 0 or config bit 8 is set. Otherwise it compares all 64 bits.
- R5: A comparator write arms the channel. An armed channel matches on the first clock edge at which (comparator - counter), taken as a signed number at the active width, is zero or negative. A one-shot match disarms the channel.
- R6: After a periodic match, the comparator gains the period once per cycle until it is ahead of the counter. No event is produced during this catch-up. A zero period makes the match behave as one-shot.
- R7: In 32-bit mode, each period addition is truncated to 32 bits and the comparator high half becomes 0.
- R8: In one-shot 32-bit mode, a counter step whose low word goes from 0xFFFFFFFF to 0 is an event. In periodic mode or 64-bit mode, that step is not an event.
- R9: While config bit 3 (periodic) is set, a write to a comparator half also loads the same half of the period register.
- R10: When config bit 2 is clear, irq_o stays low. Status still sets, and the comparator still advances.
- R11: An event sets status_o. A status write with stat_wdata=1 clears it, and one with stat_wdata=0 has no effect. If a set and a clear fall on the same edge, the set wins.
- R12: irq_o is high for exactly the one cycle after the edge that sees the event.
- R13: The routing word at offsets 0x10 (low) and 0x14 (high) is read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 64 | Main counter value |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Status write data (1 clears) |
| irq_o | output | 1 | One-cycle interrupt request |
| status_o | output | 1 | Sticky event status |

## Verification
The bench goes after several corner cases where a faulty design would misbehave in a visible way.

- **Periodic catch-up.** The counter jumps several periods past the comparator. A design without catch-up would fire a burst of pulses. A design with catch-up but without the suppression would also emit extra pulses, and its comparator would land below the counter instead of at 0x50.
- **Forced narrow mode.** Low words are chosen so that a 64-bit compare would fire at once and a 32-bit compare would not. The bench also checks a period addition that carries past bit 31; without truncation, a carry would leak into the high half.
- **Rollover.** The low word rolls over in the one-shot, periodic and 64-bit cases. This exposes a design that interrupts on wrap in the wrong modes, or one that treats a comparator in the past as never reached.
- **Register masking and enable gating.** The bench checks the read-only mask, the independence of the two comparator halves, write-one-to-clear status, and enable gating.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
   localparam int REG_W  = 32;
   localparam int CMP_W  = 64;
   localparam int ADDR_W = 5;

   // byte offsets inside the channel window
   localparam logic [ADDR_W-1:0] OFS_CFG_LO = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_CFG_HI = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_CMP_LO = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_CMP_HI = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_RT_LO  = 5'h10;
   localparam logic [ADDR_W-1:0] OFS_RT_HI  = 5'h14;

   // configuration bits that software cannot change
   localparam logic [REG_W-1:0] CFG_RO_MASK = 32'hFFFF_80B1;

   localparam int B_IRQ_EN   = 2;
   localparam int B_PERIODIC = 3;
   localparam int B_PER_CAP  = 4;
   localparam int B_WIDE_CAP = 5;
   localparam int B_FORCE32  = 8;

   typedef struct packed {
      logic irq_en;
      logic periodic;
   } chan_mode_t;
endpackage

// File: rtl/evtc_cfg_regs.sv
module evtc_cfg_regs
   import evtc_pkg::*;
#(
   parameter int WIDE_CAP = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              rt_wr_lo,
   input  logic              rt_wr_hi,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  cfg_word,
   output logic [CMP_W-1:0]  route_q,
   output chan_mode_t        mode,
   output logic              mode32
);
   localparam logic [REG_W-1:0] CFG_RST =
      (REG_W'(1) << B_PER_CAP) | (REG_W'(WIDE_CAP) << B_WIDE_CAP);

   logic [REG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RST;
      end else if (cfg_wr) begin
         cfg_q <= (cfg_q & CFG_RO_MASK) | (wdata & ~CFG_RO_MASK);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
      end else begin
         if (rt_wr_lo) route_q[REG_W-1:0]     <= wdata;
         if (rt_wr_hi) route_q[CMP_W-1:REG_W] <= wdata;
      end
   end

   generate
      if (WIDE_CAP != 0) begin : g_wide
         assign mode32 = cfg_q[B_FORCE32];
      end else begin : g_narrow
         assign mode32 = 1'b1;
      end
   endgenerate

   assign mode.irq_en   = cfg_q[B_IRQ_EN];
   assign mode.periodic = cfg_q[B_PERIODIC];
   assign cfg_word      = cfg_q;

   AST_RO_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> ((cfg_q & CFG_RO_MASK) == $past(cfg_q & CFG_RO_MASK))); // R2
endmodule

// File: rtl/evtc_cmp_core.sv
module evtc_cmp_core
   import evtc_pkg::*;
#(
   parameter int HALF_W = 32,
   parameter int FULL_W = 64
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FULL_W-1:0] cnt_i,
   input  logic              periodic,
   input  logic              mode32,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [HALF_W-1:0] wdata,
   output logic [FULL_W-1:0] cmp_q,
   output logic              match_ev
);
   localparam int N_HALF = FULL_W / HALF_W;

   generate
      if (N_HALF != 2) begin : g_bad_width
         $error("comparator must be exactly two halves wide");
      end
   endgenerate

   logic [FULL_W-1:0] per_q, per_nxt, cmp_wr_val, sum, adv_val, diff_w;
   logic [HALF_W-1:0] diff_n;
   logic [N_HALF-1:0] half_wr;
   logic armed_q, catch_q, due, per_ok, fire, adv, cmp_wr;

   assign half_wr = {wr_hi, wr_lo};
   assign cmp_wr  = |half_wr;

   for (genvar h = 0; h < N_HALF; h++) begin : g_half
      assign cmp_wr_val[h*HALF_W +: HALF_W] =
         half_wr[h] ? wdata : cmp_q[h*HALF_W +: HALF_W];
      assign per_nxt[h*HALF_W +: HALF_W] =
         (half_wr[h] && periodic) ? wdata : per_q[h*HALF_W +: HALF_W];
   end

   // wrap-safe distance from counter to comparator
   assign diff_w = cmp_q - cnt_i;
   assign diff_n = cmp_q[HALF_W-1:0] - cnt_i[HALF_W-1:0];
   assign due    = mode32 ? ($signed(diff_n) <= $signed({HALF_W{1'b0}}))
                          : ($signed(diff_w) <= $signed({FULL_W{1'b0}}));

   assign per_ok = periodic && (mode32 ? (per_q[HALF_W-1:0] != '0) : (per_q != '0));
   assign fire   = armed_q && !catch_q && due;
   assign adv    = per_ok && (fire || (catch_q && due));

   assign sum     = cmp_q + per_q;
   assign adv_val = mode32 ? {{(FULL_W-HALF_W){1'b0}}, sum[HALF_W-1:0]} : sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q   <= '1;
         per_q   <= '0;
         armed_q <= 1'b0;
         catch_q <= 1'b0;
      end else begin
         per_q <= per_nxt;
         if (cmp_wr) begin
            cmp_q   <= cmp_wr_val;
            armed_q <= 1'b1;
            catch_q <= 1'b0;
         end else begin
            if (adv) cmp_q <= adv_val;
            catch_q <= adv;
            if (fire && !per_ok) armed_q <= 1'b0;
         end
      end
   end

   assign match_ev = fire;

   AST_HALF_KEEP_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> (cmp_q[FULL_W-1:HALF_W] == $past(cmp_q[FULL_W-1:HALF_W]))); // R3
   AST_HALF_KEEP_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> (cmp_q[HALF_W-1:0] == $past(cmp_q[HALF_W-1:0]))); // R3
   AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (match_ev && !periodic && !cmp_wr) |=> !armed_q); // R5
   AST_TRUNC_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && mode32 && !cmp_wr) |=> (cmp_q[FULL_W-1:HALF_W] == '0)); // R7
endmodule

// File: rtl/evtc_irq_gen.sv
module evtc_irq_gen
   import evtc_pkg::*;
#(
   parameter int LO_W = 32
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LO_W-1:0] cnt_lo,
   input  logic            match_ev,
   input  logic            wrap_en,
   input  logic            irq_en,
   input  logic            stat_wr,
   input  logic            stat_wdata,
   output logic            irq_o,
   output logic            status_o
);
   logic [LO_W-1:0] prev_lo_q;
   logic prev_vld_q, wrap_ev, ev, irq_q, stat_q;

   assign wrap_ev = wrap_en && prev_vld_q && (prev_lo_q == '1) && (cnt_lo == '0);
   assign ev      = match_ev || wrap_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lo_q  <= '0;
         prev_vld_q <= 1'b0;
         irq_q      <= 1'b0;
         stat_q     <= 1'b0;
      end else begin
         prev_lo_q  <= cnt_lo;
         prev_vld_q <= 1'b1;
         irq_q      <= ev && irq_en;
         if (ev)                        stat_q <= 1'b1;
         else if (stat_wr && stat_wdata) stat_q <= 1'b0;
      end
   end

   assign irq_o    = irq_q;
   assign status_o = stat_q;

   AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !irq_o); // R10
   AST_STATUS_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> status_o); // R11
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && stat_wdata && !ev) |=> !status_o); // R11
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
   import evtc_pkg::*;
#(
   parameter int          WIDE_CAP  = 1,
   parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [63:0] cnt_i,
   input  logic        bus_wr,
   input  logic [4:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        stat_wr,
   input  logic        stat_wdata,
   output logic        irq_o,
   output logic        status_o
);
   generate
      if (WIDE_CAP < 0 || WIDE_CAP > 1) begin : g_bad_cap
         $error("WIDE_CAP must be 0 or 1");
      end
   endgenerate

   logic [REG_W-1:0] cfg_word;
   logic [CMP_W-1:0] route_q, cmp_q;
   chan_mode_t       mode;
   logic             mode32, match_ev;

   logic wr_cfg, wr_cmp_lo, wr_cmp_hi, wr_rt_lo, wr_rt_hi;
   assign wr_cfg    = bus_wr && (bus_addr == OFS_CFG_LO);
   assign wr_cmp_lo = bus_wr && (bus_addr == OFS_CMP_LO);
   assign wr_cmp_hi = bus_wr && (bus_addr == OFS_CMP_HI);
   assign wr_rt_lo  = bus_wr && (bus_addr == OFS_RT_LO);
   assign wr_rt_hi  = bus_wr && (bus_addr == OFS_RT_HI);

   evtc_cfg_regs #(.WIDE_CAP(WIDE_CAP)) cfg_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(wr_cfg),
      .rt_wr_lo(wr_rt_lo), .rt_wr_hi(wr_rt_hi), .wdata(bus_wdata),
      .cfg_word(cfg_word), .route_q(route_q), .mode(mode), .mode32(mode32));

   evtc_cmp_core #(.HALF_W(REG_W), .FULL_W(CMP_W)) core_i (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .periodic(mode.periodic),
      .mode32(mode32), .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi), .wdata(bus_wdata),
      .cmp_q(cmp_q), .match_ev(match_ev));

   evtc_irq_gen #(.LO_W(REG_W)) irq_i (
      .clk(clk), .rst_n(rst_n), .cnt_lo(cnt_i[REG_W-1:0]), .match_ev(match_ev),
      .wrap_en(mode32 && !mode.periodic), .irq_en(mode.irq_en),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata),
      .irq_o(irq_o), .status_o(status_o));

   always_comb begin
      unique case (bus_addr)
         OFS_CFG_LO: bus_rdata = cfg_word;
         OFS_CFG_HI: bus_rdata = ROUTE_CAP;
         OFS_CMP_LO: bus_rdata = cmp_q[REG_W-1:0];
         OFS_CMP_HI: bus_rdata = cmp_q[CMP_W-1:REG_W];
         OFS_RT_LO:  bus_rdata = route_q[REG_W-1:0];
         OFS_RT_HI:  bus_rdata = route_q[CMP_W-1:REG_W];
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: tb/evt_cmp_channel_tb_top.sv
`timescale 1ns/100ps
module evt_cmp_channel_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cnt = '0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        stat_wr = 1'b0, stat_wdata = 1'b0;
   logic        irq_o, status_o;

   int checks = 0, errors = 0, pulses = 0;
   bit done = 0;

   localparam logic [4:0] A_CFG = 5'h00, A_CFGH = 5'h04, A_CL = 5'h08,
                          A_CH = 5'h0C, A_RL = 5'h10, A_RH = 5'h14;

   always #2 clk = ~clk;

   evt_cmp_channel dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .stat_wr(stat_wr), .stat_wdata(stat_wdata),
      .irq_o(irq_o), .status_o(status_o));

   always @(posedge clk) begin
      #1;
      if (irq_o) pulses++;
   end

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic clear_status();
      stat_wr = 1'b1; stat_wdata = 1'b1;
      tick(1);
      stat_wr = 1'b0; stat_wdata = 1'b0;
   endtask

   task automatic quiesce(input logic [63:0] c);
      wr(A_CFG, 32'h0);
      cnt = c;
      tick(3);
      clear_status();
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(A_CL, d);  check("R1 cmp lo", d, 32'hFFFF_FFFF);
      rd(A_CH, d);  check("R1 cmp hi", d, 32'hFFFF_FFFF);
      rd(A_CFG, d); check("R1 cfg", d, 32'h30);
      check("R1 irq", irq_o, 0);
      check("R1 status", status_o, 0);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      wr(A_CFG, 32'hFFFF_FFFF);
      rd(A_CFG, d); check("R2 mask ones", d, 32'h7F7E);
      wr(A_CFG, 32'h0);
      rd(A_CFG, d); check("R2 mask zero", d, 32'h30);
      wr(A_CFGH, 32'h1234_5678);
      rd(A_CFGH, d); check("R2 cfg hi ro", d, 32'h00F0_0000);
   endtask

   task automatic t_halves();
      logic [31:0] d;
      wr(A_CL, 32'h1234);
      rd(A_CH, d); check("R3 hi kept", d, 32'hFFFF_FFFF);
      wr(A_CH, 32'h0);
      rd(A_CL, d); check("R3 lo kept", d, 32'h1234);
   endtask

   task automatic t_oneshot();
      logic [31:0] d;
      quiesce(64'h100);
      wr(A_CFG, 32'h4);
      wr(A_CL, 32'h105);
      cnt = 64'h104; tick(1); check("R5 early no irq", irq_o, 0);
      cnt = 64'h105; tick(1); check("R5 match irq", irq_o, 1);
      check("R11 status set", status_o, 1);
      cnt = 64'h106; tick(1); check("R12 one cycle", irq_o, 0);
      tick(2); check("R5 disarmed", irq_o, 0);
      rd(A_CL, d); check("R5 no advance", d, 32'h105);
      stat_wr = 1'b1; stat_wdata = 1'b0; tick(1); stat_wr = 1'b0;
      check("R11 write zero keeps", status_o, 1);
      clear_status();
      check("R11 write one clears", status_o, 0);
   endtask

   task automatic t_past();
      quiesce(64'h200);
      wr(A_CFG, 32'h4);
      wr(A_CL, 32'h100);
      tick(1); check("R5 past fires", irq_o, 1);
   endtask

   task automatic t_periodic();
      logic [31:0] d;
      int p;
      quiesce(64'h0);
      wr(A_CFG, 32'hC);
      wr(A_CH, 32'h0);
      wr(A_CL, 32'h10);
      cnt = 64'h10; tick(1); check("R6 first match", irq_o, 1);
      tick(1);
      rd(A_CL, d); check("R9 period reload", d, 32'h20);
      cnt = 64'h45; tick(1); check("R6 late match", irq_o, 1);
      p = pulses;
      tick(4);
      check("R6 no catchup pulses", pulses, p);
      rd(A_CL, d); check("R6 cmp ahead", d, 32'h50);
      cnt = 64'h50; tick(1); check("R6 next match", irq_o, 1);
   endtask

   task automatic t_narrow();
      logic [31:0] d;
      int p;
      quiesce(64'h1_0000_0008);
      wr(A_CFG, 32'h10C);
      wr(A_CL, 32'h10);
      p = pulses;
      tick(2); check("R4 low word compare", pulses, p);
      cnt = 64'h1_0000_0010; tick(1); check("R4 narrow match", irq_o, 1);
      tick(1);
      rd(A_CL, d); check("R4 advanced", d, 32'h20);
      quiesce(64'h1_A000_0000);
      wr(A_CFG, 32'h10C);
      wr(A_CL, 32'hC000_0000);
      p = pulses;
      cnt = 64'h1_C000_0000; tick(6);
      check("R7 single pulse", pulses, p + 1);
      rd(A_CL, d); check("R7 lo truncated", d, 32'h0);
      rd(A_CH, d); check("R7 hi zero", d, 32'h0);
   endtask

   task automatic t_wrap();
      int p;
      quiesce(64'h0_FFFF_FF00);
      wr(A_CFG, 32'h104);
      wr(A_CL, 32'h5000_0000);
      cnt = 64'h0_FFFF_FFFF; tick(1); check("R8 pre wrap", irq_o, 0);
      cnt = 64'h1_0000_0000; tick(1); check("R8 wrap irq", irq_o, 1);
      quiesce(64'h0_FFFF_FF00);
      wr(A_CFG, 32'h10C);
      wr(A_CL, 32'h5000_0000);
      p = pulses;
      cnt = 64'h0_FFFF_FFFF; tick(1);
      cnt = 64'h1_0000_0000; tick(2); check("R8 periodic no wrap", pulses, p);
      quiesce(64'h0_FFFF_FF00);
      wr(A_CFG, 32'h4);
      wr(A_CH, 32'h1);
      wr(A_CL, 32'h10);
      p = pulses;
      cnt = 64'h0_FFFF_FFFF; tick(1);
      cnt = 64'h1_0000_0000; tick(2); check("R8 wide no wrap", pulses, p);
      cnt = 64'h1_0000_0010; tick(1); check("R4 wide match", irq_o, 1);
      wr(A_CH, 32'h0);
   endtask

   task automatic t_disabled();
      logic [31:0] d;
      int p;
      quiesce(64'h300);
      p = pulses;
      wr(A_CL, 32'h100);
      tick(2);
      check("R10 status without irq", status_o, 1);
      check("R10 no pulse", pulses, p);
      quiesce(64'h10);
      wr(A_CFG, 32'h8);
      wr(A_CH, 32'h0);
      wr(A_CL, 32'h10);
      tick(3);
      check("R10 periodic silent", pulses, p);
      rd(A_CL, d); check("R10 cmp advances", d, 32'h20);
   endtask

   task automatic t_route();
      logic [31:0] d;
      wr(A_RL, 32'hA5A5_0001);
      wr(A_RH, 32'h0000_5A5A);
      rd(A_RL, d); check("R13 route lo", d, 32'hA5A5_0001);
      rd(A_RH, d); check("R13 route hi", d, 32'h0000_5A5A);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_mask();
      t_halves();
      t_oneshot();
      t_past();
      t_periodic();
      t_narrow();
      t_wrap();
      t_disabled();
      t_route();
      finish_run();
   end
endmodule